// File: doc/BRIEF.md
# Programmable Integer Clock Divider

This block derives one output clock from one input clock. A compile-time parameter picks the ratio: an integer from one to eight, or a pass-through setting in which the input clock goes straight to the output. For ratios of two and above, the output comes from a register clocked by the input. A phase counter sets where the output rises and falls, so every transition lines up with a rising input edge.

Two control inputs shape the output. A level-sensitive enable freezes the phase counter and parks the output low while it is deasserted. An asynchronous, active-high clear resets the counter and forces the output low at once. For the ratio of one, the output is the input clock passed through a low-transparent latch gate. In the pass-through setting the output is the raw input and both controls are ignored. The block sits where a local slower clock is needed for deserialising or for crossing into a slower domain.

Top module: `clk_int_divider`

## Requirements
- R1: For an even ratio N (2, 4, 6, 8) with enable held high and clear low, the output has a period of N input cycles and is high for N/2 of them.
- R2: For an odd ratio N (3, 5, 7) with enable high and clear low, the output has a period of N input cycles, is high for (N-1)/2 cycles and low for (N+1)/2 cycles, and changes only on rising input edges.
- R3: After clear is released with enable high, the output first rises on the Nth rising input edge, and not before.
- R4: A rising input edge seen with enable low drives a divided output low and leaves the phase counter where it was. On re-enable, counting resumes from that phase.
- R5: While clear is high, the output is low, without waiting for an input edge. A clear pulse that starts and ends between two input edges still restarts the count from zero.
- R6: With ratio 1, the output copies the input clock in each high phase whose preceding low phase ended with enable high and clear low. Otherwise the output is low.
- R7: With the pass-through setting (parameter value 0), the output equals the input clock whatever enable and clear do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Source clock |
| en_i | input | 1 | Active-high enable; low parks the output low |
| clr_i | input | 1 | Active-high asynchronous clear of count and output |
| clk_o | output | 1 | Divided, gated or passed-through clock |

## Verification
The hardest case to reach is a clear pulse that opens and closes inside one low phase of the input clock. No rising edge ever samples it, so only the asynchronous path can restart the count. The bench raises and drops clear two time units apart between edges and samples the outputs in that window. A second hard case is resuming from a pause taken in the middle of a high phase. The bench drives an irregular enable pattern across all nine ratio settings at once, so pauses fall on every phase of the counter.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
    localparam int unsigned DIV_BYPASS = 0;
    localparam int unsigned DIV_MAX    = 8;

    function automatic int unsigned phase_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic int unsigned high_len(input int unsigned n);
        return n / 2;
    endfunction
endpackage

// File: rtl/cdiv_phase_ctr.sv
module cdiv_phase_ctr
    import cdiv_pkg::*;
#(
    parameter int unsigned RATIO = 4,
    localparam int unsigned PW = phase_width(RATIO)
) (
    input  logic          clk_i,
    input  logic          clr_i,
    input  logic          adv_i,
    output logic [PW-1:0] phase_o,
    output logic [PW-1:0] phase_nx_o,
    output logic          wrap_o
);
    localparam logic [PW-1:0] LAST = PW'(RATIO - 1);

    typedef struct packed {
        logic [PW-1:0] phase;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv_i) begin
            if (st_q.phase == LAST) st_d.phase = '0;
            else                    st_d.phase = st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk_i or posedge clr_i) begin
        if (clr_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign phase_o    = st_q.phase;
    assign phase_nx_o = st_d.phase;
    assign wrap_o     = adv_i && (st_q.phase == LAST);

    // R1: phase never leaves 0..N-1
    p_phase_range_r1: assert property (@(posedge clk_i) disable iff (clr_i)
        phase_o <= LAST);

    // R4: no advance request means the phase holds
    p_freeze_r4: assert property (@(posedge clk_i) disable iff (clr_i)
        !adv_i |=> $stable(phase_o));
endmodule

// File: rtl/cdiv_wave_gen.sv
module cdiv_wave_gen
    import cdiv_pkg::*;
#(
    parameter int unsigned RATIO = 4,
    localparam int unsigned PW = phase_width(RATIO)
) (
    input  logic          clk_i,
    input  logic          clr_i,
    input  logic          en_i,
    input  logic          wrap_i,
    input  logic [PW-1:0] phase_i,
    input  logic [PW-1:0] phase_nx_i,
    output logic          out_o
);
    localparam logic [PW-1:0] HIGH_CNT = PW'(high_len(RATIO));

    typedef struct packed {
        logic armed;
        logic out;
    } wave_t;

    wave_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.armed = st_q.armed | (en_i & wrap_i);
        if (en_i) st_d.out = st_d.armed && (phase_nx_i < HIGH_CNT);
        else      st_d.out = 1'b0;
    end

    always_ff @(posedge clk_i or posedge clr_i) begin
        if (clr_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign out_o = st_q.out;

    // R4: an edge taken with enable low leaves the output low
    p_low_when_off_r4: assert property (@(posedge clk_i) disable iff (clr_i)
        !en_i |=> !out_o);

    // R1: the output is high only in the first half of the counter's cycle
    p_duty_r1: assert property (@(posedge clk_i) disable iff (clr_i)
        out_o |-> (phase_i < HIGH_CNT));

    // R3: no rise before the counter has wrapped once since clear
    p_no_early_rise_r3: assert property (@(posedge clk_i) disable iff (clr_i)
        (!st_q.armed && !wrap_i) |=> !out_o);
endmodule

// File: rtl/cdiv_pass_gate.sv
module cdiv_pass_gate (
    input  logic clk_i,
    input  logic clr_i,
    input  logic en_i,
    output logic clk_o
);
    logic gate_d, gate_q;

    always_comb gate_d = en_i & ~clr_i;

    // transparent while the source clock is low, so the gate never changes in a high phase
    always_latch begin
        if (clr_i)       gate_q <= 1'b0;
        else if (!clk_i) gate_q <= gate_d;
    end

    assign clk_o = clk_i & gate_q;
endmodule

// File: rtl/clk_int_divider.sv
module clk_int_divider
    import cdiv_pkg::*;
#(
    parameter int unsigned RATIO = 4
) (
    input  logic clk_i,
    input  logic en_i,
    input  logic clr_i,
    output logic clk_o
);
    initial begin
        if (RATIO > DIV_MAX) $fatal(1, "clk_int_divider: ratio %0d is not supported", RATIO);
    end

    if (RATIO == DIV_BYPASS) begin : g_bypass
        assign clk_o = clk_i;
    end else if (RATIO == 1) begin : g_unity
        cdiv_pass_gate u_gate (
            .clk_i (clk_i),
            .clr_i (clr_i),
            .en_i  (en_i),
            .clk_o (clk_o)
        );
    end else begin : g_divide
        localparam int unsigned PW = phase_width(RATIO);
        logic [PW-1:0] phase_q, phase_nx;
        logic          wrap;

        cdiv_phase_ctr #(.RATIO(RATIO)) u_ctr (
            .clk_i      (clk_i),
            .clr_i      (clr_i),
            .adv_i      (en_i),
            .phase_o    (phase_q),
            .phase_nx_o (phase_nx),
            .wrap_o     (wrap)
        );

        cdiv_wave_gen #(.RATIO(RATIO)) u_wave (
            .clk_i      (clk_i),
            .clr_i      (clr_i),
            .en_i       (en_i),
            .wrap_i     (wrap),
            .phase_i    (phase_q),
            .phase_nx_i (phase_nx),
            .out_o      (clk_o)
        );
    end
endmodule

// File: tb/test_clk_int_divider.sv
module test_clk_int_divider;
    localparam int CLK_P = 10;
    localparam int NCFG  = 9;

    logic clk = 1'b0;
    logic en  = 1'b0;
    logic clr = 1'b1;
    logic [NCFG-1:0] outs;

    int    checks = 0;
    int    fails  = 0;
    string scen   = "";

    int edges [NCFG];
    bit exp_o [NCFG];
    bit gate1;

    always #(CLK_P/2) clk = ~clk;

    for (genvar k = 0; k < NCFG; k++) begin : g_dut
        clk_int_divider #(.RATIO(k)) i_clk_int_divider (
            .clk_i (clk),
            .en_i  (en),
            .clr_i (clr),
            .clk_o (outs[k])
        );
    end

    // behavioural reference: count enabled edges since the last clear
    always @(posedge clk) begin
        for (int k = 2; k < NCFG; k++) begin
            if (clr) begin
                edges[k] = 0;
                exp_o[k] = 1'b0;
            end else if (en) begin
                edges[k] = edges[k] + 1;
                exp_o[k] = (edges[k] >= k) && ((edges[k] % k) < (k / 2));
            end else begin
                exp_o[k] = 1'b0;
            end
        end
        gate1 = !clr && en;
    end

    always @(posedge clr) begin
        for (int k = 2; k < NCFG; k++) begin
            edges[k] = 0;
            exp_o[k] = 1'b0;
        end
        gate1 = 1'b0;
    end

    function automatic string tag_of(int k);
        if (scen != "") return scen;
        if (k == 0) return "R7";
        if (k == 1) return "R6";
        if (k % 2 == 1) return "R2";
        return "R1";
    endfunction

    function automatic bit expect_of(int k, bit hi);
        if (k == 0) return hi;
        if (k == 1) return hi && !clr && gate1;
        return !clr && exp_o[k];
    endfunction

    task automatic check_all(bit hi);
        for (int k = 0; k < NCFG; k++) begin
            bit e;
            e = expect_of(k, hi);
            checks++;
            if (outs[k] !== e) begin
                fails++;
                $display("FAIL %s ratio=%0d t=%0t got=%b expected=%b", tag_of(k), k, $time, outs[k], e);
            end
        end
    endtask

    always begin
        @(posedge clk);
        #2 check_all(1'b1);
        #5 check_all(1'b0);
    end

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", checks, fails);
    endtask

    initial begin
        #(CLK_P * 20000);
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        // R5: reset state with clear held high
        scen = "R5";
        en   = 1'b1;
        repeat (3) @(posedge clk);
        // R3: first rising edge after release
        @(posedge clk); #6 clr = 1'b0; scen = "R3";
        repeat (10) @(posedge clk);
        scen = "";
        repeat (40) @(posedge clk);
        // R4: pause then resume
        @(posedge clk); #6 en = 1'b0; scen = "R4";
        repeat (5) @(posedge clk);
        @(posedge clk); #6 en = 1'b1;
        repeat (20) @(posedge clk);
        // R5: clear held across one edge, then R3 restart
        @(posedge clk); #6 clr = 1'b1; scen = "R5";
        @(posedge clk); #6 clr = 1'b0; scen = "R3";
        repeat (20) @(posedge clk);
        // R4: irregular enable pattern
        scen = "R4";
        for (int i = 0; i < 30; i++) begin
            @(posedge clk); #6 en = (i % 3 != 0) && (i % 7 != 4);
        end
        @(posedge clk); #6 en = 1'b1; scen = "";
        repeat (10) @(posedge clk);
        // R5: clear pulse inside one low phase, never seen by an edge
        @(posedge clk); #6 clr = 1'b1; scen = "R5";
        #2 clr = 1'b0;
        repeat (2) @(posedge clk);
        scen = "R3";
        repeat (20) @(posedge clk);
        scen = "";
        repeat (20) @(posedge clk);
        #3;
        summary();
        $finish;
    end
endmodule